// File: doc/BRIEF.md
# Three-Output PWM Timer Channel

This block is a 16-bit up-counting timer that produces up to three pulse-width-modulated outputs. One period compare value is shared by all outputs, and each output has its own duty compare value. The counter clears when it reaches the period value, so a period lasts (period + 1) count ticks. Each output switches to its active level after the tick on which the counter equals its duty value. It returns to its inactive level after the tick on which the counter equals the period value.

The count tick comes from one of several sources. It can be the system clock divided by 1, 2, 4, 8 or 32, a tick pulse from a fast on-chip oscillator, or an external clock pin. The external pin is synchronised, and either its rising or its falling edge counts. Software starts and stops the count. An optional self-stop mode halts the count at the end of a period. The block keeps sticky flags for compare matches, counter wrap and a forced-cutoff input. While the cutoff flag is set, every enabled output is driven to its inactive level.

Top module: `pwm3_timer`

## Requirements
- R1: After reset the counter reads 0, the count is stopped, every flag is 0 and every output pin is 0.
- R2: `clk_sel` picks the count tick: 0 every clock, 1 every 2nd, 2 every 4th, 3 every 8th, 4 every 32nd clock (free-running divider), 5 each cycle `osc_tick` is high, 6 the external pin. While running, the counter advances by one per tick.
- R3: With `clk_sel`=6 the counter advances once per rising edge of `ext_clk` when `ext_edge_fall`=0, and once per falling edge when it is 1. The edge passes through a two-stage synchroniser.
- R4: On a tick where the counter equals `period_val`, the counter goes to 0. A period is therefore `period_val`+1 ticks.
- R5: For output i with duty n < period m, the pin takes its active level after the tick at count n and its inactive level after the tick at count m. The pin is inactive for n+1 ticks and active for m−n ticks.
- R6: An output whose duty value is greater than or equal to `period_val` keeps the level it was given at start and never toggles.
- R7: `act_high[i]`=1 makes high the active level of pin i, and 0 makes low its active level. A start write loads each pin's level from `init_lvl[i]`. A pin with `out_en[i]`=0 drives 0.
- R8: A one-cycle `run_wr` pulse sets the run state to `run_wr_val`. While stopped, the counter and all pins hold their values.
- R9: With `auto_stop`=1 the count stops on the tick where the counter equals `period_val`. The counter is then 0 and the pins hold their post-match levels.
- R10: `match_flags` bit 0 is set when the counter equals `period_val` on a tick, and bit i+1 when it equals the duty value of output i. The bits stay set until the matching `flag_clr` bit is pulsed.
- R11: `ovf_flag` is set when the counter wraps from all ones to 0 on a tick, and stays set until `ovf_clr` is pulsed.
- R12: `cnt_wr` loads `cnt_wr_data` into the counter on the next edge, even while running, and takes priority over a tick in that cycle.
- R13: `cutoff_in` latches `cutoff_flag` on the next edge. While it is set, every enabled pin drives its inactive level. `cutoff_clr` clears it when `cutoff_in` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 3 | Count tick source select |
| ext_edge_fall | input | 1 | External pin edge: 0 rising, 1 falling |
| osc_tick | input | 1 | Fast-oscillator tick pulse (synchronous) |
| ext_clk | input | 1 | External count clock pin (asynchronous) |
| run_wr | input | 1 | Write strobe for run state |
| run_wr_val | input | 1 | Run state written: 1 start, 0 stop |
| auto_stop | input | 1 | Stop at period match when 1 |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wr_data | input | 16 | Value written to the counter |
| cnt_value | output | 16 | Current counter value |
| running | output | 1 | Count is running |
| period_val | input | 16 | Shared period compare value |
| duty_val | input | 3x16 | Per-output duty compare values |
| out_en | input | 3 | Per-output enable |
| act_high | input | 3 | Per-output active level |
| init_lvl | input | 3 | Per-output level loaded at start |
| cutoff_in | input | 1 | Forced cutoff request |
| cutoff_clr | input | 1 | Clear strobe for the cutoff flag |
| flag_clr | input | 4 | Clear strobes for the match flags |
| ovf_clr | input | 1 | Clear strobe for the wrap flag |
| pwm_out | output | 3 | PWM output pins |
| match_flags | output | 4 | Sticky compare-match flags |
| ovf_flag | output | 1 | Sticky counter-wrap flag |
| cutoff_flag | output | 1 | Latched cutoff flag |

## Verification
The bench compares every pin cycle by cycle against a model of the two-match waveform. It covers a zero duty value and a duty value equal to the period, which must never toggle. A design with an off-by-one match shows up as a pin that flips one tick early or late, and a wrong equality boundary shows up as a spurious toggle. The bench also checks that a stop and a self-stop at the period match leave the counter and pins frozen, with the self-stop landing on count 0. It checks that a counter write in the same cycle as a tick wins over the tick. It also checks that a counter preloaded above the period wraps and sets the wrap flag. Each prescaler ratio and each external edge polarity is confirmed by the exact number of counts over a fixed window, so a wrong divider tap or an inverted edge gives the wrong count.

// File: rtl/pwm3_pkg.sv
// Shared types and constants for the three-output PWM timer.
// Assumes a single synchronous clock domain for all users.
package pwm3_pkg;
    // Width of the free-running prescaler (largest ratio is 32)
    localparam int DIV_W = 5;

    // Count tick source codes, as seen on the clk_sel port
    typedef enum logic [2:0] {
        CS_DIV1  = 3'd0,
        CS_DIV2  = 3'd1,
        CS_DIV4  = 3'd2,
        CS_DIV8  = 3'd3,
        CS_DIV32 = 3'd4,
        CS_OSC   = 3'd5,
        CS_EXT   = 3'd6
    } clk_src_e;
endpackage

// File: rtl/pwm3_tick_gen.sv
// Count tick generator: picks a prescaled system clock, a fast-oscillator
// tick or a synchronised external pin edge and produces a one-cycle tick.
// Assumes osc_tick is already synchronous; ext_clk may be asynchronous.
module pwm3_tick_gen
    import pwm3_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    input  logic       ext_edge_fall,
    input  logic       osc_tick,
    input  logic       ext_clk,
    output logic       tick
);
    logic [DIV_W-1:0]       div_cnt;
    logic [SYNC_STAGES-1:0] ext_sync;
    logic                   ext_prev;
    logic                   ext_edge;
    logic                   sync_top;

    assign sync_top = ext_sync[SYNC_STAGES-1];

    // Free-running prescaler shared by all divided sources
    always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 1'b1;
    end

    // Synchroniser chain and previous-level register for the external pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_sync <= '0;
            ext_prev <= 1'b0;
        end else begin
            ext_sync <= {ext_sync[SYNC_STAGES-2:0], ext_clk};
            ext_prev <= sync_top;
        end
    end

    // Edge detect on the synchronised pin, polarity chosen by ext_edge_fall
    always_comb begin
        if (ext_edge_fall) ext_edge = ext_prev & ~sync_top;
        else               ext_edge = ~ext_prev & sync_top;
    end

    // Source multiplexer
    always_comb begin
        case (clk_src_e'(clk_sel))
            CS_DIV1:  tick = 1'b1;
            CS_DIV2:  tick = div_cnt[0];
            CS_DIV4:  tick = &div_cnt[1:0];
            CS_DIV8:  tick = &div_cnt[2:0];
            CS_DIV32: tick = &div_cnt[4:0];
            CS_OSC:   tick = osc_tick;
            CS_EXT:   tick = ext_edge;
            default:  tick = 1'b0;
        endcase
    end

    AST_DIV2_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == CS_DIV2 && tick) |=> (clk_sel != CS_DIV2 || !tick)); // R2
endmodule

// File: rtl/pwm3_counter.sv
// Up counter with run control, software load, period clear and self-stop.
// Assumes tick is a one-cycle enable; a software load overrides the tick.
module pwm3_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_wr,
    input  logic             run_wr_val,
    input  logic             auto_stop,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic [CNT_W-1:0] period_val,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             advance,
    output logic             period_hit,
    output logic             wrap_hit,
    output logic             start_load
);
    // A tick is counted only while running and not overridden by a load
    assign advance    = running & tick & ~cnt_wr;
    assign period_hit = advance & (cnt == period_val);
    assign wrap_hit   = advance & (&cnt) & ~(cnt == period_val);
    assign start_load = run_wr & run_wr_val & ~running;

    // Run state: software write first, then self-stop at period match
    always_ff @(posedge clk) begin
        if (!rst_n)                       running <= 1'b0;
        else if (run_wr)                  running <= run_wr_val;
        else if (period_hit && auto_stop) running <= 1'b0;
    end

    // Counter value: load, clear at period, or increment
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt_wr)     cnt <= cnt_wr_data;
        else if (period_hit) cnt <= '0;
        else if (advance)    cnt <= cnt + 1'b1;
    end

    AST_CLEAR_AT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        period_hit |=> (cnt == '0)); // R4
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> $stable(cnt)); // R8
    AST_SELF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (period_hit && auto_stop && !run_wr) |=> !running); // R9
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(cnt_wr_data))); // R12
endmodule

// File: rtl/pwm3_channel.sv
// One PWM output: level register set active at its duty match, set
// inactive at the shared period match, loaded with its initial level at
// start. Assumes period_hit and advance come from the shared counter.
module pwm3_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             period_hit,
    input  logic             start_load,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_val,
    input  logic [CNT_W-1:0] period_val,
    input  logic             act_high,
    input  logic             init_lvl,
    input  logic             out_en,
    input  logic             cutoff_active,
    output logic             duty_hit,
    output logic             pin
);
    logic lvl;
    logic toggles;

    // Only a duty below the period produces a waveform
    assign toggles  = duty_val < period_val;
    assign duty_hit = advance & (cnt == duty_val);

    // Output level state
    always_ff @(posedge clk) begin
        if (!rst_n)                            lvl <= 1'b0;
        else if (start_load)                   lvl <= init_lvl;
        else if (toggles && period_hit)        lvl <= ~act_high;
        else if (toggles && duty_hit)          lvl <= act_high;
    end

    // Pin driver: disabled drives 0, cutoff drives the inactive level
    always_comb begin
        if (!out_en)            pin = 1'b0;
        else if (cutoff_active) pin = ~act_high;
        else                    pin = lvl;
    end

    AST_NO_TOGGLE_HIGH_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggles && !start_load && $stable(duty_val) && $stable(period_val))
        |=> $stable(lvl)); // R6
endmodule

// File: rtl/pwm3_status.sv
// Sticky flag bank for compare matches, counter wrap and forced cutoff.
// A set request in the same cycle as a clear wins over the clear.
module pwm3_status #(
    parameter int NUM_MATCH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_MATCH-1:0] match_set,
    input  logic [NUM_MATCH-1:0] match_clr,
    input  logic                 wrap_set,
    input  logic                 wrap_clr,
    input  logic                 cutoff_in,
    input  logic                 cutoff_clr,
    output logic [NUM_MATCH-1:0] match_flags,
    output logic                 ovf_flag,
    output logic                 cutoff_flag
);
    // One sticky bit per compare register
    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_match
        always_ff @(posedge clk) begin
            if (!rst_n)            match_flags[g] <= 1'b0;
            else if (match_set[g]) match_flags[g] <= 1'b1;
            else if (match_clr[g]) match_flags[g] <= 1'b0;
        end
    end

    // Counter wrap flag
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (wrap_set) ovf_flag <= 1'b1;
        else if (wrap_clr) ovf_flag <= 1'b0;
    end

    // Forced cutoff latch
    always_ff @(posedge clk) begin
        if (!rst_n)          cutoff_flag <= 1'b0;
        else if (cutoff_in)  cutoff_flag <= 1'b1;
        else if (cutoff_clr) cutoff_flag <= 1'b0;
    end

    AST_CUTOFF_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        cutoff_in |=> cutoff_flag); // R13
    AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !wrap_clr) |=> ovf_flag); // R11
    AST_MATCH0_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        match_set[0] |=> match_flags[0]); // R10
endmodule

// File: rtl/pwm3_timer.sv
// Top of the PWM timer channel: tick generator, shared counter, one
// output stage per PWM pin and the flag bank. All inputs are synchronous
// except ext_clk.
module pwm3_timer #(
    parameter int CNT_W       = 16,
    parameter int NUM_OUT     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    clk_sel,
    input  logic                          ext_edge_fall,
    input  logic                          osc_tick,
    input  logic                          ext_clk,
    input  logic                          run_wr,
    input  logic                          run_wr_val,
    input  logic                          auto_stop,
    input  logic                          cnt_wr,
    input  logic [CNT_W-1:0]              cnt_wr_data,
    output logic [CNT_W-1:0]              cnt_value,
    output logic                          running,
    input  logic [CNT_W-1:0]              period_val,
    input  logic [NUM_OUT-1:0][CNT_W-1:0] duty_val,
    input  logic [NUM_OUT-1:0]            out_en,
    input  logic [NUM_OUT-1:0]            act_high,
    input  logic [NUM_OUT-1:0]            init_lvl,
    input  logic                          cutoff_in,
    input  logic                          cutoff_clr,
    input  logic [NUM_OUT:0]              flag_clr,
    input  logic                          ovf_clr,
    output logic [NUM_OUT-1:0]            pwm_out,
    output logic [NUM_OUT:0]              match_flags,
    output logic                          ovf_flag,
    output logic                          cutoff_flag
);
    localparam int NUM_MATCH = NUM_OUT + 1;

    logic               tick;
    logic               advance;
    logic               period_hit;
    logic               wrap_hit;
    logic               start_load;
    logic [NUM_OUT-1:0] duty_hit;

    pwm3_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
        .ext_edge_fall(ext_edge_fall), .osc_tick(osc_tick),
        .ext_clk(ext_clk), .tick(tick)
    );

    pwm3_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .run_wr(run_wr), .run_wr_val(run_wr_val), .auto_stop(auto_stop),
        .cnt_wr(cnt_wr), .cnt_wr_data(cnt_wr_data), .period_val(period_val),
        .cnt(cnt_value), .running(running), .advance(advance),
        .period_hit(period_hit), .wrap_hit(wrap_hit), .start_load(start_load)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        pwm3_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .advance(advance),
            .period_hit(period_hit), .start_load(start_load),
            .cnt(cnt_value), .duty_val(duty_val[i]), .period_val(period_val),
            .act_high(act_high[i]), .init_lvl(init_lvl[i]),
            .out_en(out_en[i]), .cutoff_active(cutoff_flag),
            .duty_hit(duty_hit[i]), .pin(pwm_out[i])
        );

        AST_CUTOFF_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
            (cutoff_in && out_en[i] && $stable(out_en[i]) && $stable(act_high[i]))
            |=> (pwm_out[i] == ~act_high[i])); // R13
    end

    pwm3_status #(.NUM_MATCH(NUM_MATCH)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .match_set({duty_hit, period_hit}), .match_clr(flag_clr),
        .wrap_set(wrap_hit), .wrap_clr(ovf_clr),
        .cutoff_in(cutoff_in), .cutoff_clr(cutoff_clr),
        .match_flags(match_flags), .ovf_flag(ovf_flag),
        .cutoff_flag(cutoff_flag)
    );

    AST_WRAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && (&cnt_value) && (cnt_value != period_val)) |=> ovf_flag); // R11
endmodule

// File: tb/pwm3_timer_test.sv
// Scoreboard bench: the driver pushes expected pin vectors, the monitor
// pops and compares them one negedge later.
module pwm3_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  clk_sel = 3'd0;
    logic        ext_edge_fall = 1'b0, osc_tick = 1'b0, ext_clk = 1'b0;
    logic        run_wr = 1'b0, run_wr_val = 1'b0, auto_stop = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_wr_data = '0;
    logic [15:0] cnt_value;
    logic        running;
    logic [15:0] period_val = 16'd9;
    logic [2:0][15:0] duty_val = '0;
    logic [2:0]  out_en = '0, act_high = '0, init_lvl = '0;
    logic        cutoff_in = 1'b0, cutoff_clr = 1'b0;
    logic [3:0]  flag_clr = '0;
    logic        ovf_clr = 1'b0;
    logic [2:0]  pwm_out;
    logic [3:0]  match_flags;
    logic        ovf_flag, cutoff_flag;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] exp_q[$];
    string      wave_tag = "";

    always #10 clk = ~clk;   // 50 MHz

    pwm3_timer uut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
        .ext_edge_fall(ext_edge_fall), .osc_tick(osc_tick), .ext_clk(ext_clk),
        .run_wr(run_wr), .run_wr_val(run_wr_val), .auto_stop(auto_stop),
        .cnt_wr(cnt_wr), .cnt_wr_data(cnt_wr_data), .cnt_value(cnt_value),
        .running(running), .period_val(period_val), .duty_val(duty_val),
        .out_en(out_en), .act_high(act_high), .init_lvl(init_lvl),
        .cutoff_in(cutoff_in), .cutoff_clr(cutoff_clr), .flag_clr(flag_clr),
        .ovf_clr(ovf_clr), .pwm_out(pwm_out), .match_flags(match_flags),
        .ovf_flag(ovf_flag), .cutoff_flag(cutoff_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected pin vector per negedge
    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            e = exp_q.pop_front();
            check(pwm_out == e, wave_tag, pwm_out, e);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_cnt(input logic [15:0] v);
        cnt_wr = 1'b1; cnt_wr_data = v;
        cycles(1);
        cnt_wr = 1'b0;
    endtask

    task automatic set_run(input bit v);
        run_wr = 1'b1; run_wr_val = v;
        cycles(1);
        run_wr = 1'b0;
    endtask

    // Expected pin vector for the state after the tick at count c
    function automatic logic [2:0] model(input int c, input int m);
        logic [2:0] r;
        for (int i = 0; i < 3; i++) begin
            bit act;
            act  = (int'(duty_val[i]) < m) && (c >= int'(duty_val[i])) && (c < m);
            r[i] = out_en[i] & (act ? act_high[i] : ~act_high[i]);
        end
        return r;
    endfunction

    // Driver: start from count 0 and push the expected waveform
    task automatic drive_wave(input string tag, input int n);
        int m;
        m = int'(period_val);
        wave_tag = tag;
        load_cnt(16'd0);
        set_run(1'b1);
        exp_q.push_back(init_lvl & out_en);
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            exp_q.push_back(model((k - 1) % (m + 1), m));
        end
        cycles(1);
    endtask

    // Count ticks over a fixed window
    task automatic window_count(input int n, input int exp, input string tag);
        logic [15:0] c0;
        load_cnt(16'd0);
        set_run(1'b1);
        c0 = cnt_value;
        cycles(n);
        check(cnt_value - c0 == 16'(exp), tag, cnt_value - c0, exp);
        set_run(1'b0);
    endtask

    task automatic ext_pulses(input int n);
        for (int k = 0; k < n; k++) begin
            ext_clk = ~ext_clk; cycles(4);
            ext_clk = ~ext_clk; cycles(4);
        end
    endtask

    initial begin
        logic [2:0]  p_hold;
        logic [15:0] c_hold;
        logic [15:0] c_a;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        check(cnt_value == 0, "R1 counter", cnt_value, 0);
        check(!running, "R1 run", running, 0);
        check(match_flags == 0 && !ovf_flag && !cutoff_flag, "R1 flags",
              {match_flags, ovf_flag, cutoff_flag}, 0);
        check(pwm_out == 0, "R1 pins", pwm_out, 0);

        // R5 R7 R6: mixed levels, zero duty, duty above period
        out_en = 3'b111; period_val = 16'd9;
        duty_val[0] = 16'd3; duty_val[1] = 16'd0; duty_val[2] = 16'd12;
        act_high = 3'b010; init_lvl = 3'b101;
        drive_wave("R5 R7 R6 wave A", 25);
        // R10 match flags: duty ch2 (12) never hit
        check(match_flags == 4'b0111, "R10 flags", match_flags, 4'b0111);
        flag_clr = 4'hF; cycles(1); flag_clr = 4'h0;
        set_run(1'b0);
        check(match_flags == 4'b0000, "R10 clear", match_flags, 0);

        // R8 stop holds
        p_hold = pwm_out; c_hold = cnt_value;
        cycles(10);
        check(pwm_out == p_hold, "R8 pins hold", pwm_out, p_hold);
        check(cnt_value == c_hold, "R8 count hold", cnt_value, c_hold);

        // R6 duty equal to period, active high, pattern B
        period_val = 16'd4;
        duty_val[0] = 16'd4; duty_val[1] = 16'd1; duty_val[2] = 16'd2;
        act_high = 3'b111; init_lvl = 3'b000;
        drive_wave("R6 R5 wave B", 15);
        set_run(1'b0);

        // R7 disabled pin drives 0
        out_en = 3'b101;
        cycles(1);
        check(pwm_out[1] == 1'b0, "R7 disabled pin", pwm_out[1], 0);
        out_en = 3'b111;

        // R9 self-stop at period match
        duty_val[0] = 16'd1; duty_val[1] = 16'd2; duty_val[2] = 16'd3;
        init_lvl = 3'b111; auto_stop = 1'b1;
        load_cnt(16'd0);
        set_run(1'b1);
        check(pwm_out == 3'b111, "R7 init load", pwm_out, 3'b111);
        cycles(8);
        check(!running, "R9 stopped", running, 0);
        check(cnt_value == 0, "R9 count", cnt_value, 0);
        check(pwm_out == 3'b000, "R9 pins", pwm_out, 0);
        check(match_flags[0], "R10 period flag", match_flags[0], 1);
        auto_stop = 1'b0;

        // R11 wrap with counter above period
        ovf_clr = 1'b1; cycles(1); ovf_clr = 1'b0;
        period_val = 16'd9;
        load_cnt(16'hFFFD);
        set_run(1'b1);
        cycles(1);
        check(!ovf_flag, "R11 no early wrap", ovf_flag, 0);
        cycles(3);
        check(ovf_flag, "R11 wrap", ovf_flag, 1);
        check(cnt_value == 16'd1, "R11 count", cnt_value, 1);

        // R12 load while running wins over tick
        period_val = 16'd100;
        load_cnt(16'd5);
        check(cnt_value == 16'd5, "R12 load", cnt_value, 5);
        cycles(1);
        check(cnt_value == 16'd6, "R12 next", cnt_value, 6);

        // R13 cutoff
        act_high = 3'b010;
        cutoff_in = 1'b1; cycles(1); cutoff_in = 1'b0;
        check(cutoff_flag, "R13 flag", cutoff_flag, 1);
        for (int k = 0; k < 3; k++) begin
            check(pwm_out == 3'b101, "R13 forced", pwm_out, 3'b101);
            cycles(1);
        end
        cutoff_clr = 1'b1; cycles(1); cutoff_clr = 1'b0;
        check(!cutoff_flag, "R13 clear", cutoff_flag, 0);
        set_run(1'b0);

        // R2 prescaler ratios and oscillator tick
        period_val = 16'hFFFF;
        clk_sel = 3'd1; window_count(40, 20, "R2 div2");
        clk_sel = 3'd2; window_count(40, 10, "R2 div4");
        clk_sel = 3'd3; window_count(40, 5, "R2 div8");
        clk_sel = 3'd4; window_count(64, 2, "R2 div32");
        clk_sel = 3'd5;
        load_cnt(16'd0); set_run(1'b1);
        for (int k = 0; k < 7; k++) begin
            osc_tick = 1'b1; cycles(1); osc_tick = 1'b0; cycles(2);
        end
        check(cnt_value == 16'd7, "R2 osc", cnt_value, 7);
        set_run(1'b0);

        // R3 external edges
        clk_sel = 3'd6; ext_edge_fall = 1'b0; ext_clk = 1'b0;
        cycles(4);
        load_cnt(16'd0); set_run(1'b1);
        ext_pulses(3);
        c_a = cnt_value;
        check(c_a == 16'd3, "R3 rising", c_a, 3);
        ext_edge_fall = 1'b1;
        ext_pulses(2);
        check(cnt_value == 16'd5, "R3 falling", cnt_value, 5);
        set_run(1'b0);

        cycles(2);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule